// File: doc/BRIEF.md
# Indexed-Mask Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines into one interrupt output for a processor. Each line has a status bit and an enable bit. The status bit tracks the synchronized level of its line. The processor output goes high whenever at least one line is both active and enabled. Status bits cannot be cleared by software. They drop only when the requesting source releases its line.

Software changes enable bits one line at a time. It writes the number of a line to one register to disable that line, and it writes the number to another register to enable it again. No bitmap is ever written. A single read-only register returns the status word.

The register bus is a plain synchronous interface with an address, write and read strobes, write data and registered read data. An error flag reports any access the map does not allow. The request lines pass through a synchronizer. The output is registered.

Top module: `idxmask_irq_ctrl`

## Requirements
- R1: The status word reads back bit i as 1 while request line i is high and as 0 while it is low. A change on a line becomes readable after two rising edges and is not visible after the first one.
- R2: `cpu_irq` is a register. It is 1 exactly one clock after (status AND enable) becomes nonzero, and 0 one clock after that AND becomes zero. From a change on a request line to the output this makes three rising edges.
- R3: Reset sets all enable bits to 1 and clears status, `cpu_irq`, `bus_rd_data` and `bus_err`. Any line raised after reset therefore reaches the output without any setup.
- R4: A write to offset 0x4 clears enable bit N, where N is `bus_wr_data[4:0]`. Higher data bits are ignored, and every other enable bit keeps its value.
- R5: A write to offset 0x8 sets enable bit N, where N is `bus_wr_data[4:0]`. Every other enable bit keeps its value.
- R6: Offset 0x0 is read-only. A write to it changes no enable bit and raises `bus_err` for one cycle.
- R7: A read of offset 0x4 or 0x8 returns zero and raises `bus_err`.
- R8: Any offset other than 0x0, 0x4 and 0x8 is unimplemented. This includes unaligned offsets and offsets that agree with a valid one only in the low bits. A write to such an offset changes no state, and a read returns zero. Both raise `bus_err`.
- R9: A read of offset 0x0 returns the status word, zero-extended, on `bus_rd_data` one clock after the read strobe, with `bus_err` low. When no legal status read is in progress, `bus_rd_data` is zero.
- R10: When an enable write and a status change take effect on the same rising edge, the next `cpu_irq` value is computed from both new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_LINES (32) | Level-sensitive interrupt requests, asynchronous |
| bus_addr | input | ADDR_W (8) | Byte offset of the register access |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wr_data | input | DATA_W (32) | Write data; the low 5 bits carry the line index |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_rd_data | output | DATA_W (32) | Registered read data, valid one clock after `bus_rd_en` |
| bus_err | output | 1 | Registered access-error pulse, one clock after an illegal access |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds the block with its default values: 32 lines, a two-stage synchronizer, an 8-bit address and a 32-bit data word. With an 8-bit address the bench can use offsets such as 0x84, which match a legal register only in the low bits, and show that partial decoding would corrupt the enable word. With 32 lines the walk visits every value of the 5-bit index. That covers both edge indices and shows that each enable bit is reached by exactly one index value. Because the synchronizer depth is two, the three-edge latency from a line to `cpu_irq` can be timed exactly. It also lets the bench land a line change and an index write on the same edge.

// File: rtl/idxmask_irq_pkg.sv
package idxmask_irq_pkg;

  // Register offsets (byte addresses, word aligned).
  localparam int unsigned OFF_STATUS = 32'h0;
  localparam int unsigned OFF_MASK   = 32'h4;
  localparam int unsigned OFF_UNMASK = 32'h8;

  // Classification of a write strobe.
  typedef enum logic [1:0] {
    WR_IDLE   = 2'd0,
    WR_MASK   = 2'd1,
    WR_UNMASK = 2'd2,
    WR_BAD    = 2'd3
  } wr_kind_e;

  // Classification of a read strobe.
  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_BAD    = 2'd2
  } rd_kind_e;

endpackage

// File: rtl/idxmask_irq_sync.sv
// Multi-stage level synchronizer; the last stage is the status register.
module idxmask_irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[LAST];

endmodule

// File: rtl/idxmask_irq_decode.sv
// Register bus decoder: classifies strobes, produces enable-edit strobes,
// registered read data and the access-error pulse.
module idxmask_irq_decode
  import idxmask_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr_en,
  input  logic [DATA_W-1:0]    bus_wr_data,
  input  logic                 bus_rd_en,
  input  logic [NUM_LINES-1:0] status_q,
  output logic                 mask_stb,
  output logic                 unmask_stb,
  output logic [IDX_W-1:0]     line_idx,
  output logic                 status_rd,
  output logic                 bad_access,
  output logic [DATA_W-1:0]    bus_rd_data,
  output logic                 bus_err
);

  function automatic wr_kind_e classify_wr(input logic en, input logic [ADDR_W-1:0] a);
    if (!en)                         return WR_IDLE;
    if (a == ADDR_W'(OFF_MASK))      return WR_MASK;
    if (a == ADDR_W'(OFF_UNMASK))    return WR_UNMASK;
    return WR_BAD;
  endfunction

  function automatic rd_kind_e classify_rd(input logic en, input logic [ADDR_W-1:0] a);
    if (!en)                         return RD_IDLE;
    if (a == ADDR_W'(OFF_STATUS))    return RD_STATUS;
    return RD_BAD;
  endfunction

  wr_kind_e wr_kind;
  rd_kind_e rd_kind;

  always_comb begin
    wr_kind = classify_wr(bus_wr_en, bus_addr);
    rd_kind = classify_rd(bus_rd_en, bus_addr);
  end

  assign mask_stb   = (wr_kind == WR_MASK);
  assign unmask_stb = (wr_kind == WR_UNMASK);
  assign line_idx   = bus_wr_data[IDX_W-1:0];
  assign status_rd  = (rd_kind == RD_STATUS);
  assign bad_access = (wr_kind == WR_BAD) || (rd_kind == RD_BAD);

  logic [DATA_W-1:0] rd_q;
  logic              err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      rd_q  <= status_rd ? DATA_W'(status_q) : '0;
      err_q <= bad_access;
    end
  end

  assign bus_rd_data = rd_q;
  assign bus_err     = err_q;

endmodule

// File: rtl/idxmask_irq_enable.sv
// Enable word edited one bit at a time by index.
module idxmask_irq_enable #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned IDX_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mask_stb,
  input  logic                 unmask_stb,
  input  logic [IDX_W-1:0]     line_idx,
  output logic [NUM_LINES-1:0] enable_q
);

  // Next enable word after an optional clear or set of one indexed bit.
  function automatic logic [NUM_LINES-1:0] edit_enable(
    input logic [NUM_LINES-1:0] cur,
    input logic                 clr,
    input logic                 set,
    input logic [IDX_W-1:0]     idx
  );
    logic [NUM_LINES-1:0] nxt;
    nxt = cur;
    for (int i = 0; i < int'(NUM_LINES); i++) begin
      if (idx == IDX_W'(i)) begin
        if (clr)      nxt[i] = 1'b0;
        else if (set) nxt[i] = 1'b1;
      end
    end
    return nxt;
  endfunction

  logic [NUM_LINES-1:0] enable_d;

  always_comb enable_d = edit_enable(enable_q, mask_stb, unmask_stb, line_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enable_q <= '1;
    else        enable_q <= enable_d;
  end

endmodule

// File: rtl/idxmask_irq_ctrl.sv
// Top: synchronizer + status, index-edited enable word, bus decode,
// registered processor interrupt.
module idxmask_irq_ctrl #(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr_en,
  input  logic [DATA_W-1:0]    bus_wr_data,
  input  logic                 bus_rd_en,
  output logic [DATA_W-1:0]    bus_rd_data,
  output logic                 bus_err,
  output logic                 cpu_irq
);

  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  // Any line both active and enabled.
  function automatic logic any_pending(
    input logic [NUM_LINES-1:0] st,
    input logic [NUM_LINES-1:0] en
  );
    return |(st & en);
  endfunction

  // Named internal events, exposed for the bound checker.
  logic [NUM_LINES-1:0] status_q;
  logic [NUM_LINES-1:0] enable_q;
  logic                 mask_stb;
  logic                 unmask_stb;
  logic [IDX_W-1:0]     line_idx;
  logic                 status_rd;
  logic                 bad_access;
  logic                 pending_now;

  idxmask_irq_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_lines),
    .sync_out (status_q)
  );

  idxmask_irq_decode #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W)
  ) u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .bus_rd_en   (bus_rd_en),
    .status_q    (status_q),
    .mask_stb    (mask_stb),
    .unmask_stb  (unmask_stb),
    .line_idx    (line_idx),
    .status_rd   (status_rd),
    .bad_access  (bad_access),
    .bus_rd_data (bus_rd_data),
    .bus_err     (bus_err)
  );

  idxmask_irq_enable #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W)
  ) u_enable (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_stb   (mask_stb),
    .unmask_stb (unmask_stb),
    .line_idx   (line_idx),
    .enable_q   (enable_q)
  );

  assign pending_now = any_pending(status_q, enable_q);

  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending_now;
  end

  assign cpu_irq = irq_q;

endmodule

// File: rtl/idxmask_irq_ctrl_chk.sv
module idxmask_irq_ctrl_chk #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_W     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] status_q,
  input logic [NUM_LINES-1:0] enable_q,
  input logic                 mask_stb,
  input logic                 unmask_stb,
  input logic [IDX_W-1:0]     line_idx,
  input logic                 status_rd,
  input logic                 bad_access,
  input logic                 bus_rd_en,
  input logic [DATA_W-1:0]    bus_rd_data,
  input logic                 bus_err,
  input logic                 cpu_irq
);

  logic idx_in_range;
  assign idx_in_range = (32'(line_idx) < NUM_LINES);

  AST_IRQ_TRACKS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_irq == $past(|(status_q & enable_q)))); // R2

  AST_MASK_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_stb && idx_in_range) |=> !enable_q[$past(line_idx)]); // R4

  AST_UNMASK_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (unmask_stb && idx_in_range) |=> enable_q[$past(line_idx)]); // R5

  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_stb && !unmask_stb) |=> $stable(enable_q)); // R8

  AST_ONE_BIT_EDIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_stb || unmask_stb) |=> ($countones(enable_q ^ $past(enable_q)) <= 1)); // R4

  AST_ERR_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |=> bus_err); // R8

  AST_NO_ERR_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_access |=> !bus_err); // R9

  AST_READ_ZERO_ELSEWHERE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !status_rd) |=> (bus_rd_data == '0)); // R7

endmodule

bind idxmask_irq_ctrl idxmask_irq_ctrl_chk #(
  .NUM_LINES (NUM_LINES),
  .DATA_W    (DATA_W),
  .IDX_W     (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .status_q    (status_q),
  .enable_q    (enable_q),
  .mask_stb    (mask_stb),
  .unmask_stb  (unmask_stb),
  .line_idx    (line_idx),
  .status_rd   (status_rd),
  .bad_access  (bad_access),
  .bus_rd_en   (bus_rd_en),
  .bus_rd_data (bus_rd_data),
  .bus_err     (bus_err),
  .cpu_irq     (cpu_irq)
);

// File: tb/idxmask_irq_ctrl_tb.sv
module idxmask_irq_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic [NL-1:0] irq_lines;
  logic [AW-1:0] bus_addr;
  logic          bus_wr_en;
  logic [DW-1:0] bus_wr_data;
  logic          bus_rd_en;
  logic [DW-1:0] bus_rd_data;
  logic          bus_err;
  logic          cpu_irq;

  idxmask_irq_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_lines   (irq_lines),
    .bus_addr    (bus_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .bus_rd_en   (bus_rd_en),
    .bus_rd_data (bus_rd_data),
    .bus_err     (bus_err),
    .cpu_irq     (cpu_irq)
  );

  // Scoreboard item: what to observe, when, and which value is expected.
  typedef struct {
    int          due;
    int          kind;   // 0 cpu_irq, 1 bus_rd_data, 2 bus_err
    logic [31:0] val;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  logic [31:0] lines_m;
  logic [31:0] en_m;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] observe(input int kind);
    if (kind == 0) return {31'd0, cpu_irq};
    if (kind == 1) return bus_rd_data;
    return {31'd0, bus_err};
  endfunction

  function automatic string kind_name(input int kind);
    if (kind == 0) return "cpu_irq";
    if (kind == 1) return "bus_rd_data";
    return "bus_err";
  endfunction

  // Monitor: pops every item due in this cycle and compares it.
  always @(negedge clk) begin
    int          k;
    logic [31:0] act;
    k = 0;
    while (k < sb.size()) begin
      if (sb[k].due == cyc) begin
        checks++;
        act = observe(sb[k].kind);
        if (act !== sb[k].val) begin
          fails++;
          $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)",
                   sb[k].req, kind_name(sb[k].kind), act, sb[k].val, cyc);
        end
        sb.delete(k);
      end else begin
        k++;
      end
    end
  end

  task automatic push(input int d, input int kind, input logic [31:0] v, input string req);
    exp_t e;
    e.due  = cyc + d;
    e.kind = kind;
    e.val  = v;
    e.req  = req;
    sb.push_back(e);
  endtask

  task automatic direct_check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: one write strobe; model the enable word from the requirements.
  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic bad, input string req);
    bus_addr    = a;
    bus_wr_data = d;
    bus_wr_en   = 1'b1;
    push(1, 2, {31'd0, bad}, req);
    @(negedge clk);
    bus_wr_en = 1'b0;
    if (!bad && a == 8'h04) en_m[d[4:0]] = 1'b0;
    if (!bad && a == 8'h08) en_m[d[4:0]] = 1'b1;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                        input logic bad, input string req);
    bus_addr  = a;
    bus_rd_en = 1'b1;
    push(1, 1, exp, req);
    push(1, 2, {31'd0, bad}, req);
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic drive_lines(input logic [31:0] v);
    irq_lines = v;
    lines_m   = v;
  endtask

  // Expect the output d edges from now, from the reference model.
  task automatic expect_irq(input int d, input string req);
    push(d, 0, {31'd0, |(lines_m & en_m)}, req);
    tick(d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    bus_addr    = '0;
    bus_wr_en   = 1'b0;
    bus_wr_data = '0;
    bus_rd_en   = 1'b0;
    lines_m     = '0;
    en_m        = '1;
    irq_lines   = '0;
    tick(3);
    // R3: reset state of outputs
    direct_check({31'd0, cpu_irq}, 32'd0, "R3 cpu_irq in reset");
    direct_check({31'd0, bus_err}, 32'd0, "R3 bus_err in reset");
    direct_check(bus_rd_data, 32'd0, "R3 bus_rd_data in reset");
    rst_n = 1'b1;
    tick(1);

    // R9: status reads zero after reset, no error
    bus_rd(8'h00, 32'd0, 1'b0, "R9");
    expect_irq(1, "R3");

    // R3/R2/R1: line 5 reaches output with default enables, three edges later
    drive_lines(32'h1 << 5);
    push(2, 0, 32'd0, "R1 sync latency");
    push(3, 0, 32'd1, "R2 rise");
    tick(3);
    bus_rd(8'h00, 32'h1 << 5, 1'b0, "R1");

    // R4: mask index 5 with junk upper bits
    bus_wr(8'h04, 32'hABCD_EF05, 1'b0, "R4");
    expect_irq(1, "R4 masked");
    drive_lines((32'h1 << 5) | (32'h1 << 9));
    expect_irq(3, "R4 others kept");
    drive_lines(32'h1 << 5);
    expect_irq(3, "R2 fall");

    // R5: unmask index 5
    bus_wr(8'h08, 32'd5, 1'b0, "R5");
    expect_irq(1, "R5");

    // R6: status is read-only
    bus_wr(8'h00, 32'd0, 1'b1, "R6");
    expect_irq(1, "R6");
    bus_rd(8'h00, 32'h1 << 5, 1'b0, "R6");

    // R7: write-only registers read as zero with error
    bus_rd(8'h04, 32'd0, 1'b1, "R7");
    bus_rd(8'h08, 32'd0, 1'b1, "R7");

    // R8: unimplemented, unaligned and aliased offsets
    bus_wr(8'h0C, 32'd5, 1'b1, "R8");
    bus_wr(8'h05, 32'd5, 1'b1, "R8");
    bus_wr(8'h84, 32'd5, 1'b1, "R8");
    expect_irq(1, "R8 enable kept");
    bus_rd(8'h0C, 32'd0, 1'b1, "R8");
    bus_rd(8'h84, 32'd0, 1'b1, "R8");
    bus_rd(8'h02, 32'd0, 1'b1, "R8");

    // R10: status gains line 20 on the same edge enable loses line 5
    drive_lines((32'h1 << 5) | (32'h1 << 20));
    tick(1);
    bus_wr(8'h04, 32'd5, 1'b0, "R10");
    expect_irq(1, "R10");
    tick(2);

    // R4/R5 walk over every index
    drive_lines(32'd0);
    expect_irq(3, "R2");
    for (int i = 0; i < NL; i++) bus_wr(8'h04, 32'(i), 1'b0, "R4");
    drive_lines(32'hFFFF_FFFF);
    expect_irq(3, "R4 all masked");
    for (int i = 0; i < NL; i++) begin
      bus_wr(8'h08, 32'(i), 1'b0, "R5");
      expect_irq(1, "R5 walk");
      bus_wr(8'h04, 32'(i), 1'b0, "R4");
      expect_irq(1, "R4 walk");
    end
    bus_rd(8'h00, 32'hFFFF_FFFF, 1'b0, "R1");

    tick(4);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending items", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule